// File: doc/BRIEF.md
# Two-Layer Masked Tile Depth Updater

This block holds a conservative depth summary for each small screen tile of an occlusion-culling buffer. Each tile covers a fixed rectangle of pixels (8x4 by default, 32 pixels). Its record holds two maximum-depth values and one selection bit per pixel.

- **Reference layer:** its depth bounds every pixel of the tile.
- **Working layer:** its depth bounds only the pixels whose selection bit is set.

**Updates.** A rasterizer feeds fragment groups to the update port. Each group carries a tile number, a per-pixel coverage mask and a conservative maximum depth for the triangle inside the tile. The block folds each group into the working layer. When the working layer covers the whole tile, it is promoted to the reference layer. A heuristic throws away a working layer that sits much closer to the reference than to a new, nearer triangle.

**Queries.** Occlusion queries go to a second port. A query names a tile and the nearest depth of the object under test. One cycle later the block answers whether that object lies entirely behind the tile's reference depth, and it also returns that reference depth.

**Clearing.** A clear command walks through the tile store, one tile per cycle. It sets every record back to the empty state. Both ports stall while the clear runs.

Top module: `masked_tile_depth`

## Requirements
- R1: After reset every tile reads back a reference depth of all ones (farthest), and its working layer is empty (depth zero, no selection bits).
- R2: A pulse on `clr_i` while idle starts a clear that takes exactly NUM_TILES cycles. During the clear both ready outputs are low. Afterwards every tile is in the state given in R1.
- R3: An accepted fragment group sets the working depth to the larger of the working depth and the fragment depth. It sets the selection mask to the bitwise OR of the selection mask and the coverage mask.
- R4: When the resulting selection mask has all of its bits set, the reference depth takes the new working depth. The working layer then becomes empty. A stored selection mask is therefore never all ones, and the reference depth never rises except by a clear or reset.
- R5: Before merging, the working layer is emptied when two conditions both hold: its mask is non-empty, and (working depth minus fragment depth) is strictly greater than (reference depth minus working depth). The differences are signed. The fragment is then merged into the emptied layer.
- R6: A fragment group whose coverage mask is zero leaves the tile unchanged.
- R7: A fragment group whose depth is equal to or greater than the tile's reference depth leaves the tile unchanged.
- R8: A query accepted in cycle N raises `res_valid_o` for exactly cycle N+1. In that cycle `res_ref_o` carries the tile's reference depth, and `res_occluded_o` is 1 exactly when the query's minimum depth is strictly greater than that reference depth.
- R9: A query accepted in the same cycle as an update of the same tile reports the state before that update.
- R10: Outside a clear, both `upd_ready_o` and `qry_ready_o` are high, and every handshake completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Start a clear of all tiles |
| clr_busy_o | output | 1 | Clear in progress |
| upd_valid_i | input | 1 | Fragment group valid |
| upd_ready_o | output | 1 | Update port can accept |
| upd_tile_i | input | TILE_IDX_W | Tile number of the fragment group |
| upd_mask_i | input | MASK_W | Per-pixel coverage mask |
| upd_depth_i | input | DEPTH_W | Conservative triangle maximum depth |
| qry_valid_i | input | 1 | Query valid |
| qry_ready_o | output | 1 | Query port can accept |
| qry_tile_i | input | TILE_IDX_W | Tile number of the query |
| qry_zmin_i | input | DEPTH_W | Nearest depth of the tested object |
| res_valid_o | output | 1 | Query result valid |
| res_occluded_o | output | 1 | Tested object is hidden |
| res_ref_o | output | DEPTH_W | Reference depth of the queried tile |

## Verification
The bench builds the block with 4 tiles, 8-bit depths and the default 8x4 tile. With only four tiles, random streams of fragment groups revisit each record often. The mask fills up quickly, so promotions and the discard rule fire many times. The narrow depth range makes equal depths and equal gaps common. That puts the strict comparisons of R5, R7 and R8, and the ignore-at-reference case, within easy reach of both random and directed stimulus.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    localparam int TILE_W_DEF    = 8;
    localparam int TILE_H_DEF    = 4;
    localparam int DEPTH_W_DEF   = 16;
    localparam int NUM_TILES_DEF = 64;

    // outcome of folding one fragment group into a tile record
    typedef enum logic [1:0] {
        MERGE_HOLD    = 2'd0,
        MERGE_ACCUM   = 2'd1,
        MERGE_RESTART = 2'd2
    } merge_kind_e;

endpackage

// File: rtl/mtd_merge.sv
module mtd_merge
    import mtd_pkg::*;
#(
    parameter int MASK_W  = 32,
    parameter int DEPTH_W = 16
) (
    input  logic [DEPTH_W-1:0] cur_ref,
    input  logic [DEPTH_W-1:0] cur_work,
    input  logic [MASK_W-1:0]  cur_mask,
    input  logic [MASK_W-1:0]  frag_mask,
    input  logic [DEPTH_W-1:0] frag_depth,
    output logic [DEPTH_W-1:0] nxt_ref,
    output logic [DEPTH_W-1:0] nxt_work,
    output logic [MASK_W-1:0]  nxt_mask,
    output merge_kind_e        kind
);

    logic signed [DEPTH_W:0] gap_work_frag;
    logic signed [DEPTH_W:0] gap_ref_work;
    logic                    skip;
    logic                    restart;
    logic [DEPTH_W-1:0]      base_work;
    logic [MASK_W-1:0]       base_mask;
    logic [DEPTH_W-1:0]      acc_work;
    logic [MASK_W-1:0]       acc_mask;

    always_comb begin
        gap_work_frag = $signed({1'b0, cur_work}) - $signed({1'b0, frag_depth});
        gap_ref_work  = $signed({1'b0, cur_ref})  - $signed({1'b0, cur_work});
        skip          = (frag_mask == '0) || (frag_depth >= cur_ref);
        restart       = (cur_mask != '0) && (gap_work_frag > gap_ref_work);
        base_work     = restart ? '0 : cur_work;
        base_mask     = restart ? '0 : cur_mask;
        acc_work      = (frag_depth > base_work) ? frag_depth : base_work;
        acc_mask      = base_mask | frag_mask;

        if (skip) begin
            kind     = MERGE_HOLD;
            nxt_ref  = cur_ref;
            nxt_work = cur_work;
            nxt_mask = cur_mask;
        end else begin
            kind = restart ? MERGE_RESTART : MERGE_ACCUM;
            if (&acc_mask) begin
                nxt_ref  = acc_work;
                nxt_work = '0;
                nxt_mask = '0;
            end else begin
                nxt_ref  = cur_ref;
                nxt_work = acc_work;
                nxt_mask = acc_mask;
            end
        end
    end

endmodule

// File: rtl/mtd_store.sv
module mtd_store #(
    parameter int NUM_TILES = 64,
    parameter int MASK_W    = 32,
    parameter int DEPTH_W   = 16,
    localparam int IDX_W    = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_start,
    output logic               busy_o,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DEPTH_W-1:0] wr_ref,
    input  logic [DEPTH_W-1:0] wr_work,
    input  logic [MASK_W-1:0]  wr_mask,
    input  logic [IDX_W-1:0]   rda_idx,
    output logic [DEPTH_W-1:0] rda_ref,
    output logic [DEPTH_W-1:0] rda_work,
    output logic [MASK_W-1:0]  rda_mask,
    input  logic [IDX_W-1:0]   rdb_idx,
    output logic [DEPTH_W-1:0] rdb_ref
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TILES - 1);

    logic [DEPTH_W-1:0] ref_q  [NUM_TILES];
    logic [DEPTH_W-1:0] work_q [NUM_TILES];
    logic [MASK_W-1:0]  mask_q [NUM_TILES];
    logic               busy_q;
    logic [IDX_W-1:0]   sweep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sweep_q <= '0;
        end else if (busy_q) begin
            if (sweep_q == LAST_IDX) begin
                busy_q  <= 1'b0;
                sweep_q <= '0;
            end else begin
                sweep_q <= sweep_q + 1'b1;
            end
        end else if (clr_start) begin
            busy_q  <= 1'b1;
            sweep_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TILES; i++) begin
            if (rst || (busy_q && sweep_q == IDX_W'(i))) begin
                ref_q[i]  <= '1;
                work_q[i] <= '0;
                mask_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                ref_q[i]  <= wr_ref;
                work_q[i] <= wr_work;
                mask_q[i] <= wr_mask;
            end
        end
    end

    always_comb begin
        rda_ref  = '1;
        rda_work = '0;
        rda_mask = '0;
        rdb_ref  = '1;
        if (int'(rda_idx) < NUM_TILES) begin
            rda_ref  = ref_q[rda_idx];
            rda_work = work_q[rda_idx];
            rda_mask = mask_q[rda_idx];
        end
        if (int'(rdb_idx) < NUM_TILES) begin
            rdb_ref = ref_q[rdb_idx];
        end
    end

    assign busy_o = busy_q;

    // R2: the sweep runs without a break until the last tile
    assert_sweep_continues_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && sweep_q != LAST_IDX) |=> busy_q);
    assert_sweep_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && sweep_q == LAST_IDX) |=> !busy_q);
    assert_no_write_in_sweep_R2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !wr_en);

endmodule

// File: rtl/mtd_query.sv
module mtd_query #(
    parameter int DEPTH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [DEPTH_W-1:0] zmin,
    input  logic [DEPTH_W-1:0] tile_ref,
    output logic               res_valid,
    output logic               res_occluded,
    output logic [DEPTH_W-1:0] res_ref
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_occluded <= 1'b0;
            res_ref      <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_occluded <= (zmin > tile_ref);
                res_ref      <= tile_ref;
            end
        end
    end

    // R8: one result per accepted query, one cycle later
    assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> res_valid);
    assert_no_spurious_result_R8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !res_valid);

endmodule

// File: rtl/masked_tile_depth.sv
module masked_tile_depth
    import mtd_pkg::*;
#(
    parameter int  TILE_W     = TILE_W_DEF,
    parameter int  TILE_H     = TILE_H_DEF,
    parameter int  DEPTH_W    = DEPTH_W_DEF,
    parameter int  NUM_TILES  = NUM_TILES_DEF,
    localparam int MASK_W     = TILE_W * TILE_H,
    localparam int TILE_IDX_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    output logic                  clr_busy_o,
    input  logic                  upd_valid_i,
    output logic                  upd_ready_o,
    input  logic [TILE_IDX_W-1:0] upd_tile_i,
    input  logic [MASK_W-1:0]     upd_mask_i,
    input  logic [DEPTH_W-1:0]    upd_depth_i,
    input  logic                  qry_valid_i,
    output logic                  qry_ready_o,
    input  logic [TILE_IDX_W-1:0] qry_tile_i,
    input  logic [DEPTH_W-1:0]    qry_zmin_i,
    output logic                  res_valid_o,
    output logic                  res_occluded_o,
    output logic [DEPTH_W-1:0]    res_ref_o
);

    logic               busy;
    logic               upd_fire;
    logic               qry_fire;
    logic [DEPTH_W-1:0] cur_ref;
    logic [DEPTH_W-1:0] cur_work;
    logic [MASK_W-1:0]  cur_mask;
    logic [DEPTH_W-1:0] nxt_ref;
    logic [DEPTH_W-1:0] nxt_work;
    logic [MASK_W-1:0]  nxt_mask;
    logic [DEPTH_W-1:0] qry_ref;
    merge_kind_e        kind;

    assign upd_ready_o = !busy;
    assign qry_ready_o = !busy;
    assign clr_busy_o  = busy;
    assign upd_fire    = upd_valid_i && !busy;
    assign qry_fire    = qry_valid_i && !busy;

    mtd_store #(
        .NUM_TILES (NUM_TILES),
        .MASK_W    (MASK_W),
        .DEPTH_W   (DEPTH_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .clr_start (clr_i),
        .busy_o    (busy),
        .wr_en     (upd_fire),
        .wr_idx    (upd_tile_i),
        .wr_ref    (nxt_ref),
        .wr_work   (nxt_work),
        .wr_mask   (nxt_mask),
        .rda_idx   (upd_tile_i),
        .rda_ref   (cur_ref),
        .rda_work  (cur_work),
        .rda_mask  (cur_mask),
        .rdb_idx   (qry_tile_i),
        .rdb_ref   (qry_ref)
    );

    mtd_merge #(
        .MASK_W  (MASK_W),
        .DEPTH_W (DEPTH_W)
    ) merge_i (
        .cur_ref    (cur_ref),
        .cur_work   (cur_work),
        .cur_mask   (cur_mask),
        .frag_mask  (upd_mask_i),
        .frag_depth (upd_depth_i),
        .nxt_ref    (nxt_ref),
        .nxt_work   (nxt_work),
        .nxt_mask   (nxt_mask),
        .kind       (kind)
    );

    mtd_query #(
        .DEPTH_W (DEPTH_W)
    ) query_i (
        .clk          (clk),
        .rst          (rst),
        .fire         (qry_fire),
        .zmin         (qry_zmin_i),
        .tile_ref     (qry_ref),
        .res_valid    (res_valid_o),
        .res_occluded (res_occluded_o),
        .res_ref      (res_ref_o)
    );

    // R4: reference depth only moves nearer, and a full mask is never kept
    assert_ref_not_rising_R4: assert property (@(posedge clk) disable iff (rst)
        upd_fire |-> (nxt_ref <= cur_ref));
    assert_mask_never_full_R4: assert property (@(posedge clk) disable iff (rst)
        upd_fire |-> !(&nxt_mask));
    // R3: a non-empty working layer stays nearer than the reference
    assert_work_below_ref_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && nxt_mask != '0) |-> (nxt_work < nxt_ref));
    // R6: empty coverage is a hold
    assert_zero_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && upd_mask_i == '0) |-> (kind == MERGE_HOLD));
    // R7: a fragment at or behind the reference is a hold
    assert_far_frag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && upd_depth_i >= cur_ref) |-> (kind == MERGE_HOLD));
    assert_hold_keeps_record_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && kind == MERGE_HOLD) |->
        (nxt_ref == cur_ref && nxt_work == cur_work && nxt_mask == cur_mask));

endmodule

// File: tb/masked_tile_depth_tb_top.sv
module masked_tile_depth_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int DW  = 8;
    localparam int MW  = 32;
    localparam int IW  = 2;
    localparam logic [MW-1:0] FULL = '1;
    localparam logic [MW-1:0] LOW  = 32'h0000_FFFF;
    localparam logic [MW-1:0] HIGH = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          busy;
    logic          upd_valid = 1'b0;
    logic          upd_ready;
    logic [IW-1:0] upd_tile = '0;
    logic [MW-1:0] upd_mask = '0;
    logic [DW-1:0] upd_depth = '0;
    logic          qry_valid = 1'b0;
    logic          qry_ready;
    logic [IW-1:0] qry_tile = '0;
    logic [DW-1:0] qry_zmin = '0;
    logic          res_valid;
    logic          res_occ;
    logic [DW-1:0] res_ref;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_ref  [NT];
    logic [DW-1:0] m_work [NT];
    logic [MW-1:0] m_mask [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_tile_depth #(
        .TILE_W (8), .TILE_H (4), .DEPTH_W (DW), .NUM_TILES (NT)
    ) dut_i (
        .clk (clk), .rst (rst), .clr_i (clr), .clr_busy_o (busy),
        .upd_valid_i (upd_valid), .upd_ready_o (upd_ready),
        .upd_tile_i (upd_tile), .upd_mask_i (upd_mask), .upd_depth_i (upd_depth),
        .qry_valid_i (qry_valid), .qry_ready_o (qry_ready),
        .qry_tile_i (qry_tile), .qry_zmin_i (qry_zmin),
        .res_valid_o (res_valid), .res_occluded_o (res_occ), .res_ref_o (res_ref)
    );

    task automatic check(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NT; i++) begin
            m_ref[i] = '1; m_work[i] = '0; m_mask[i] = '0;
        end
    endtask

    // expected record after one fragment group
    task automatic model_update(int t, logic [MW-1:0] m, logic [DW-1:0] z);
        int w, r;
        logic [MW-1:0] mk;
        if (m == '0 || z >= m_ref[t]) return;
        w = int'(m_work[t]); r = int'(m_ref[t]); mk = m_mask[t];
        if (mk != '0 && (w - int'(z)) > (r - w)) begin
            w = 0; mk = '0;
        end
        if (int'(z) > w) w = int'(z);
        mk = mk | m;
        if (mk == FULL) begin
            m_ref[t] = DW'(w); m_work[t] = '0; m_mask[t] = '0;
        end else begin
            m_work[t] = DW'(w); m_mask[t] = mk;
        end
    endtask

    task automatic do_upd(int t, logic [MW-1:0] m, logic [DW-1:0] z);
        @(negedge clk);
        upd_valid = 1'b1; upd_tile = IW'(t); upd_mask = m; upd_depth = z;
        @(negedge clk);
        upd_valid = 1'b0;
        model_update(t, m, z);
    endtask

    task automatic do_qry(int t, logic [DW-1:0] zm, string req);
        @(negedge clk);
        qry_valid = 1'b1; qry_tile = IW'(t); qry_zmin = zm;
        @(negedge clk);
        qry_valid = 1'b0;
        check(res_valid == 1'b1, {req, " valid"}, int'(res_valid), 1);
        check(res_ref == m_ref[t], {req, " ref"}, int'(res_ref), int'(m_ref[t]));
        check(res_occ == (zm > m_ref[t]), {req, " occluded"}, int'(res_occ),
              int'(zm > m_ref[t]));
    endtask

    function automatic logic [MW-1:0] pick_mask(int k);
        case (k % 6)
            0: return FULL;
            1: return LOW;
            2: return HIGH;
            3: return '0;
            4: return MW'(1) << ($urandom % MW);
            default: return MW'($urandom);
        endcase
    endfunction

    initial begin
        repeat (20_000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, zmin equal to far is not occluded
        for (int t = 0; t < NT; t++) do_qry(t, '1, "R1");
        // R10: ready high when idle
        check(upd_ready && qry_ready, "R10 ready idle", int'(upd_ready), 1);

        // R4: single full-coverage group promotes at once
        do_upd(0, FULL, 8'd100);
        do_qry(0, 8'd101, "R4 promote occluded");
        do_qry(0, 8'd100, "R8 equal not occluded");

        // R3: two halves accumulate max depth, then promote
        do_upd(1, LOW, 8'd5);
        do_qry(1, 8'd200, "R3 partial keeps ref");
        do_upd(1, HIGH, 8'd8);
        do_qry(1, 8'd9, "R3 max of halves");

        // R5: discard fires (60-10=50 > 100-60=40)
        do_upd(0, LOW, 8'd60);
        do_upd(0, HIGH, 8'd10);
        do_upd(0, LOW, 8'd15);
        do_qry(0, 8'd16, "R5 discard");
        check(res_ref == 8'd15, "R5 discard ref", int'(res_ref), 15);

        // R5: equal gaps do not discard (ref 15, work 10, frag 5)
        do_upd(0, LOW, 8'd10);
        do_upd(0, HIGH, 8'd5);
        do_qry(0, 8'd11, "R5 equal gap keeps");
        check(res_ref == 8'd10, "R5 equal gap ref", int'(res_ref), 10);

        // R6: zero coverage with near depth changes nothing
        do_upd(2, LOW, 8'd40);
        do_upd(2, '0, 8'd1);
        do_upd(2, HIGH, 8'd30);
        do_qry(2, 8'd41, "R6 zero mask ignored");

        // R7: depth equal to reference ignored
        do_upd(2, FULL, 8'd40);
        do_qry(2, 8'd41, "R7 equal depth ignored");
        do_upd(2, FULL, 8'd39);
        do_qry(2, 8'd40, "R7 nearer accepted");

        // R9: same-cycle query sees old state
        @(negedge clk);
        upd_valid = 1'b1; upd_tile = 2'd3; upd_mask = FULL; upd_depth = 8'd50;
        qry_valid = 1'b1; qry_tile = 2'd3; qry_zmin = 8'd60;
        @(negedge clk);
        upd_valid = 1'b0; qry_valid = 1'b0;
        check(res_ref == 8'hFF, "R9 old ref", int'(res_ref), 255);
        check(res_occ == 1'b0, "R9 old occluded", int'(res_occ), 0);
        model_update(3, FULL, 8'd50);
        do_qry(3, 8'd60, "R9 new state");

        // R2: clear takes NT cycles with ready low, then all tiles far
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        begin
            int cnt = 0;
            while (!upd_ready && cnt < 100) begin
                check(!qry_ready, "R2 qry ready low", int'(qry_ready), 0);
                cnt++;
                @(negedge clk);
            end
            check(cnt == NT, "R2 clear length", cnt, NT);
        end
        model_clear();
        for (int t = 0; t < NT; t++) do_qry(t, '1, "R2 cleared");

        // random mix, R3 R4 R5 R6 R7 R8
        for (int n = 0; n < 600; n++) begin
            int t = int'($urandom % NT);
            do_upd(t, pick_mask(int'($urandom % 6)), DW'($urandom));
            if (n % 3 == 0) do_qry(t, DW'($urandom), "R8 random");
        end
        for (int t = 0; t < NT; t++) do_qry(t, DW'($urandom), "R4 random final");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule